// File: doc/BRIEF.md
# Two-Wire Slave Controller for a Wiper Setting Register

This block is the serial front end of an 8-bit setting register, such as the tap register of a digitally controlled resistor. A fast system clock oversamples the two bus lines. After a START it collects a 7-bit slave address, and it answers only when that address matches the fixed upper six bits plus one bit taken from an external select pin. Because of that pin, two such slaves can sit on one bus. SDA is never driven high. The block only asserts a pull-low enable, and an external pull-up supplies the high level.

A write transfer is always the address, then one command byte, then any number of data bytes. The command byte carries a request to return the wiper to midscale and a shutdown flag. Each data byte that follows becomes a one-cycle write strobe with its data toward the register block, and the command does not need to be sent again. A read transfer returns the register contents right after the address acknowledge. It repeats the value for as long as the master acknowledges and stops at the first master NACK. A repeated START at any point restarts address reception, and a STOP returns the block to idle.

Top module: `potreg_i2c_slave`

## Requirements
- R1: While reset is high, and in the cycle after it, sda_oe_o, wr_stb_o, mid_rst_o and shdn_o are all 0.
- R2: The address byte is sent MSB first. Bits 7..1 are 0,1,0,1,1,0 followed by addr_sel_i, and bit 0 is the direction (1 = master reads, 0 = master writes). On a match the slave holds SDA low during the ninth clock.
- R3: When the address does not match, the slave does not acknowledge. It drives no SDA and produces no strobe for any later byte until the next START.
- R4: In a write, the first byte after the address is a command. Bit 6 = 1 gives a one-cycle mid_rst_o pulse. Bit 5 sets shdn_o to its value, and shdn_o holds that value across transfers. Bits 7 and 4..0 have no effect. The command byte is acknowledged.
- R5: Every byte after the command byte is acknowledged and gives exactly one wr_stb_o cycle. wr_data_o then equals the byte, received MSB first. Data bytes keep coming until STOP or START.
- R6: In a read, rd_data_i is sent MSB first starting right after the address acknowledge. A master ACK (SDA low on the ninth clock) sends the value again. A master NACK ends the drive, and SDA stays released until the next START.
- R7: A repeated START in the middle of a byte drops that byte without a strobe and restarts address reception.
- R8: After STOP, clocked bits without a new START are ignored: no acknowledge and no strobe.
- R9: An SCL pulse shorter than FILT_LEN system clocks is not counted as a bus clock.
- R10: sda_oe_o only rises while the filtered SCL is low, and it is the only way the block drives SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Level that forms the lowest address bit |
| rd_data_i | input | 8 | Current register contents returned in reads |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_stb_o | output | 1 | One-cycle strobe for a received data byte |
| wr_data_o | output | 8 | Data byte that goes with wr_stb_o |
| mid_rst_o | output | 1 | One-cycle request to load the midscale value |
| shdn_o | output | 1 | Shutdown level from the latest command byte |

## Verification
The bench builds the block with two synchronizer stages and a three-sample filter, and runs the bus with an SCL period of 32 system clocks. With those values the bench can inject a two-clock SCL spike that a correct filter must reject, while real edges still clear the pipeline with margin inside each quarter bit. The select pin is tested at both levels, so the same address byte is a match in one run and a mismatch in another. Read values with a high MSB and with a low MSB test both released and driven first bits.

// File: rtl/potreg_pkg.sv
`timescale 1ns/1ps
package potreg_pkg;
    localparam int BYTE_W = 8;
    localparam logic [5:0] DEV_ADDR_HI = 6'b010110;
    localparam int CMD_MID_BIT  = 6;
    localparam int CMD_SHDN_BIT = 5;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_CMD, PH_WDAT, PH_RDAT, PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic sel);
        return b[BYTE_W-1:1] == {DEV_ADDR_HI, sel};
    endfunction
endpackage

// File: rtl/potreg_line_filt.sv
`timescale 1ns/1ps
module potreg_line_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/potreg_bus_cond.sv
`timescale 1ns/1ps
module potreg_bus_cond
    import potreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
        ev.sda      = sda_f;
    end
endmodule

// File: rtl/potreg_xfer_fsm.sv
`timescale 1ns/1ps
module potreg_xfer_fsm
    import potreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              mid_rst,
    output logic              shdn
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic              in_ack;
    logic              is_read;
    logic              nack_q;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            in_ack  <= 1'b0;
            is_read <= 1'b0;
            nack_q  <= 1'b1;
            sh      <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
            mid_rst <= 1'b0;
            shdn    <= 1'b0;
        end else begin
            wr_stb  <= 1'b0;
            mid_rst <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (phase == PH_IDLE || phase == PH_SKIP) begin
                sda_oe <= 1'b0;
            end else if (ev.scl_rise) begin
                if (in_ack) begin
                    nack_q <= ev.sda;
                end else if (cnt != CNT_FULL) begin
                    cnt <= cnt + 1'b1;
                    if (phase != PH_RDAT)
                        sh <= {sh[BYTE_W-2:0], ev.sda};
                end
            end else if (ev.scl_fall) begin
                if (in_ack) begin
                    // leaving the ninth clock: decide the next byte
                    in_ack <= 1'b0;
                    cnt    <= '0;
                    sda_oe <= 1'b0;
                    case (phase)
                        PH_ADDR: begin
                            if (is_read) begin
                                phase  <= PH_RDAT;
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                phase <= PH_CMD;
                            end
                        end
                        PH_CMD: phase <= PH_WDAT;
                        PH_RDAT: begin
                            if (nack_q) begin
                                phase <= PH_SKIP;
                            end else begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end
                        end
                        default: ;
                    endcase
                end else if (cnt == CNT_FULL) begin
                    // entering the ninth clock
                    in_ack <= 1'b1;
                    case (phase)
                        PH_ADDR: begin
                            if (addr_hit(sh, addr_sel)) begin
                                sda_oe  <= 1'b1;
                                is_read <= sh[0];
                            end else begin
                                phase  <= PH_SKIP;
                                sda_oe <= 1'b0;
                            end
                        end
                        PH_CMD: begin
                            sda_oe  <= 1'b1;
                            mid_rst <= sh[CMD_MID_BIT];
                            shdn    <= sh[CMD_SHDN_BIT];
                        end
                        PH_WDAT: begin
                            sda_oe  <= 1'b1;
                            wr_stb  <= 1'b1;
                            wr_data <= sh;
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (phase == PH_RDAT && cnt != '0) begin
                    sh     <= {sh[BYTE_W-2:0], 1'b0};
                    sda_oe <= ~sh[BYTE_W-2];
                end
            end
        end
    end
endmodule

// File: rtl/potreg_i2c_slave.sv
`timescale 1ns/1ps
module potreg_i2c_slave
    import potreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              mid_rst_o,
    output logic              shdn_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_w;
    logic [N_LINES-1:0] filt_w;
    logic               scl_f;
    logic               sda_f;
    bus_ev_t            ev;

    assign raw_w = {scl_i, sda_i};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        potreg_line_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_w[gi]),
            .dout(filt_w[gi])
        );
    end

    assign scl_f = filt_w[1];
    assign sda_f = filt_w[0];

    potreg_bus_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .ev   (ev)
    );

    potreg_xfer_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .addr_sel(addr_sel_i),
        .rd_data (rd_data_i),
        .sda_oe  (sda_oe_o),
        .wr_stb  (wr_stb_o),
        .wr_data (wr_data_o),
        .mid_rst (mid_rst_o),
        .shdn    (shdn_o)
    );
endmodule

// File: rtl/potreg_i2c_chk.sv
`timescale 1ns/1ps
module potreg_i2c_chk (
    input logic clk,
    input logic rst,
    input logic scl_f,
    input logic sda_oe_o,
    input logic wr_stb_o,
    input logic mid_rst_o,
    input logic shdn_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !wr_stb_o && !mid_rst_o && !shdn_o));

    p_stb_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> !scl_f);

    p_stb_not_mid_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> !mid_rst_o);

    p_mid_single_r4: assert property (@(posedge clk) disable iff (rst)
        mid_rst_o |=> !mid_rst_o);

    p_shdn_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(shdn_o) |-> !scl_f);

    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_f);
endmodule

bind potreg_i2c_slave potreg_i2c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_oe_o (sda_oe_o),
    .wr_stb_o (wr_stb_o),
    .mid_rst_o(mid_rst_o),
    .shdn_o   (shdn_o)
);

// File: tb/potreg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module potreg_i2c_slave_tb_top;
    localparam int QTR  = 8;
    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m, sda_m, addr_sel;
    logic [7:0] rd_data;
    logic       sda_oe, wr_stb, mid_rst, shdn;
    logic [7:0] wr_data;
    logic       sda_line;

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;
    logic [7:0] exp_wr[$];
    int         exp_mid = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    potreg_i2c_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .rd_data_i(rd_data), .sda_oe_o(sda_oe),
        .wr_stb_o(wr_stb), .wr_data_o(wr_data), .mid_rst_o(mid_rst),
        .shdn_o(shdn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // reference model of strobe traffic, compared on every clock
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            if (wr_stb) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R5 unexpected strobe", wr_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_wr.pop_front();
                    chk(wr_data == e, "R5 data", wr_data, e);
                end
            end
            if (mid_rst) begin
                chk(exp_mid > 0, "R4 midscale pulse", 1, exp_mid);
                if (exp_mid > 0) exp_mid--;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QTR);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(QTR);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic clock_bit(input bit b, output bit seen, input bit glitch);
        sda_m = b;
        if (glitch) begin
            tick(2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(QTR - 4);
        end else begin
            tick(QTR);
        end
        scl_m = 1'b1; tick(HALF / 2);
        seen = sda_line; tick(HALF / 2);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, input int gl = -1);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s, i == gl);
        clock_bit(1'b1, ack, 1'b0);
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s, 1'b0);
            b[i] = s;
        end
        clock_bit(!m_ack, s, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit         ack;
        bit         s;
        logic [7:0] rb;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0; rd_data = 8'h96;
        tick(10);
        chk(!sda_oe && !wr_stb && !mid_rst && !shdn, "R1 reset state",
            {sda_oe, wr_stb, mid_rst, shdn}, 0);
        rst = 1'b0;
        tick(10);
        chk(!sda_oe && !shdn, "R1 after reset", {sda_oe, shdn}, 0);

        // R2 / R5: basic write with two data bytes
        bus_start();
        send_byte(8'h58, ack); chk(ack == 0, "R2 address ack", ack, 0);
        send_byte(8'h00, ack); chk(ack == 0, "R4 command ack", ack, 0);
        exp_wr.push_back(8'hA5); send_byte(8'hA5, ack); chk(ack == 0, "R5 data ack", ack, 0);
        exp_wr.push_back(8'h3C); send_byte(8'h3C, ack); chk(ack == 0, "R5 data ack", ack, 0);
        bus_stop();
        chk(exp_wr.size() == 0, "R5 strobes seen", exp_wr.size(), 0);

        // R4: midscale request
        bus_start();
        send_byte(8'h58, ack);
        exp_mid = 1; send_byte(8'h40, ack);
        exp_wr.push_back(8'h11); send_byte(8'h11, ack);
        bus_stop();
        chk(exp_mid == 0, "R4 midscale seen", exp_mid, 0);
        chk(shdn == 0, "R4 shutdown clear", shdn, 0);

        // R4: ignored command bits
        bus_start();
        send_byte(8'h58, ack);
        send_byte(8'h9F, ack); chk(ack == 0, "R4 command ack", ack, 0);
        exp_wr.push_back(8'h00); send_byte(8'h00, ack);
        bus_stop();
        chk(shdn == 0, "R4 ignored bits", shdn, 0);

        // R4: shutdown set, held, then cleared
        bus_start();
        send_byte(8'h58, ack); send_byte(8'h20, ack);
        exp_wr.push_back(8'h7E); send_byte(8'h7E, ack);
        bus_stop();
        chk(shdn == 1, "R4 shutdown set", shdn, 1);
        bus_start();
        send_byte(8'h58, ack);
        exp_mid = 1; send_byte(8'h60, ack);
        bus_stop();
        chk(shdn == 1 && exp_mid == 0, "R4 shutdown with midscale", shdn, 1);
        bus_start();
        send_byte(8'h58, ack); send_byte(8'h00, ack);
        bus_stop();
        chk(shdn == 0, "R4 shutdown cleared", shdn, 0);

        // R3: select pin high, old address mismatches
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h58, ack); chk(ack == 1, "R3 no ack", ack, 1);
        send_byte(8'h00, ack); chk(ack == 1, "R3 ignored byte", ack, 1);
        send_byte(8'hFF, ack); chk(ack == 1, "R3 ignored byte", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'h5A, ack); chk(ack == 0, "R2 select high ack", ack, 0);
        send_byte(8'h00, ack);
        exp_wr.push_back(8'hC3); send_byte(8'hC3, ack);
        bus_stop();

        // R6: read, repeated read, NACK end
        rd_data = 8'h96;
        bus_start();
        send_byte(8'h5B, ack); chk(ack == 0, "R2 read address ack", ack, 0);
        recv_byte(1'b1, rb); chk(rb == 8'h96, "R6 first read", rb, 8'h96);
        recv_byte(1'b0, rb); chk(rb == 8'h96, "R6 repeated read", rb, 8'h96);
        recv_byte(1'b0, rb); chk(rb == 8'hFF, "R6 released after NACK", rb, 8'hFF);
        bus_stop();
        rd_data = 8'h01;
        bus_start();
        send_byte(8'h5B, ack);
        recv_byte(1'b0, rb); chk(rb == 8'h01, "R6 read low MSB", rb, 8'h01);
        bus_stop();

        // R7: repeated START in the middle of a data byte
        bus_start();
        send_byte(8'h5A, ack); send_byte(8'h00, ack);
        clock_bit(1'b1, s, 1'b0); clock_bit(1'b0, s, 1'b0); clock_bit(1'b1, s, 1'b0);
        bus_start();
        send_byte(8'h5A, ack); chk(ack == 0, "R7 restart address ack", ack, 0);
        send_byte(8'h00, ack);
        exp_wr.push_back(8'h5E); send_byte(8'h5E, ack);
        bus_stop();
        chk(exp_wr.size() == 0, "R7 only new byte", exp_wr.size(), 0);

        // R9: short SCL spike inside a data byte
        bus_start();
        send_byte(8'h5A, ack); send_byte(8'h00, ack);
        exp_wr.push_back(8'h81); send_byte(8'h81, ack, 3);
        bus_stop();
        chk(exp_wr.size() == 0, "R9 glitch rejected", exp_wr.size(), 0);

        // R8: bits after STOP with no START
        scl_m = 1'b0; tick(QTR);
        send_byte(8'h5A, ack); chk(ack == 1, "R8 idle no ack", ack, 1);
        send_byte(8'h00, ack); chk(ack == 1, "R8 idle no ack", ack, 1);
        sda_m = 1'b1; tick(QTR); scl_m = 1'b1; tick(HALF);

        tick(20);
        chk(exp_wr.size() == 0 && exp_mid == 0, "R5 model drained", exp_wr.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule